// File: doc/BRIEF.md
# Four-Channel Terminal-Count Timer Bank

The block holds four general-purpose timers that count system clock cycles. Each channel has a 64-bit control word and a read-only 64-bit count word. Software programs a terminal value and an enable bit in the control word. An enabled channel counts up by one on every clock. When the count equals the terminal value, the channel raises a pending bit and restarts from zero. A channel can also be forced back to zero by writing a one-shot clear bit.

A shared mask register and a shared pending register cover all four channels. Pending bits are cleared by writing ones to them. Each channel has its own masked interrupt line, and one combined line is the OR of the four. Access goes through a single-cycle register port. Writes take effect on the clock edge at which the request is held. Reads are combinational from the address.

Top module: `timer_bank`

## Requirements
- R1: After the asynchronous active-low reset, every register reads zero and both interrupt outputs are low.
- R2: Addresses 0 to 3 hold the control word of channels 0 to 3. Bit 63 enables the counter. Bits 61:0 hold the terminal value. Bits 63 and 61:0 read back as last written.
- R3: Addresses 4 to 7 read the counts of channels 0 to 3 in bits 61:0, with bits 63:62 zero. Writes to these addresses change nothing.
- R4: An enabled channel adds one to its count on every clock edge. A disabled channel keeps its count.
- R5: On an edge where an enabled channel's count equals its terminal value, the count becomes 0 and that channel's pending bit is set. The period is therefore terminal+1 cycles.
- R6: Writing a control word with bit 62 set zeroes the count at that edge, ahead of counting or wrapping. Bit 62 is never stored and always reads 0.
- R7: Address 8 is the mask and address 9 is the pending register. Channel i sits at bit i, so bits 3:0 are used. All higher bits read zero.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: When a terminal match and a write-1 clear of the same pending bit fall on one edge, the bit ends set.
- R10: ch_irq_o[i] is high while pending bit i and mask bit i are both set. irq_o is the OR of ch_irq_o.
- R11: Channels are independent. Programming or running one channel leaves the others' counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; counting reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for req_i |
| addr_i | input | 4 | Register index (0-3 control, 4-7 count, 8 mask, 9 pending) |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i, combinational |
| ch_irq_o | output | 4 | Per-channel masked interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
A terminal match and a software write-1 clear of the same pending bit can land on one clock edge. The bench provokes this by restarting a channel with terminal 3 through the clear bit. After exactly three more edges it issues the pending-register write, so that the write edge is the matching edge. It then expects the pending bit still set and the count at zero. A second write one cycle later must clear the bit. That proves the first result came from priority, not from a missed write.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned CNT_W_DEF  = 62;
  localparam int unsigned ADDR_W_DEF = 4;
endpackage

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int unsigned CNT_W = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             en_d_i,
  input  logic [CNT_W-1:0] term_d_i,
  input  logic             clr_i,
  output logic             en_o,
  output logic [CNT_W-1:0] term_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic             en_q;
  logic [CNT_W-1:0] term_q, cnt_q;

  assign hit_o  = en_q && (cnt_q == term_q);
  assign en_o   = en_q;
  assign term_o = term_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      term_q <= '0;
    end else if (ctrl_we_i) begin
      en_q   <= en_d_i;
      term_q <= term_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else if (en_q)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/timer_irq.sv
module timer_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [NUM_CH-1:0] mask_d_i,
  input  logic [NUM_CH-1:0] stat_clr_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] stat_o,
  output logic [NUM_CH-1:0] ch_irq_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] mask_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      // match set outranks software clear
      stat_q <= (stat_q & ~stat_clr_i) | hit_i;
    end
  end

  assign mask_o   = mask_q;
  assign stat_o   = stat_q;
  assign ch_irq_o = stat_q & mask_q;
  assign irq_o    = |ch_irq_o;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W+1:0]   wdata_i,
  output logic [CNT_W+1:0]   rdata_o,
  output logic [NUM_CH-1:0]  ch_irq_o,
  output logic               irq_o
);
  localparam int unsigned DATA_W    = CNT_W + 2;
  localparam int unsigned EN_BIT    = DATA_W - 1;
  localparam int unsigned CLR_BIT   = DATA_W - 2;
  localparam int unsigned CTRL_BASE = 0;
  localparam int unsigned CNT_BASE  = NUM_CH;
  localparam int unsigned MASK_ADDR = 2 * NUM_CH;
  localparam int unsigned STAT_ADDR = 2 * NUM_CH + 1;

  logic                         wr;
  logic [NUM_CH-1:0]            ctrl_we, clr, en, hit, mask, stat, stat_clr;
  logic [NUM_CH-1:0][CNT_W-1:0] term, cnt;
  logic                         mask_we, stat_we;

  assign wr       = req_i && we_i;
  assign mask_we  = wr && (addr_i == ADDR_W'(MASK_ADDR));
  assign stat_we  = wr && (addr_i == ADDR_W'(STAT_ADDR));
  assign stat_clr = stat_we ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ctrl_we[g] = wr && (addr_i == ADDR_W'(CTRL_BASE + g));
    assign clr[g]     = ctrl_we[g] && wdata_i[CLR_BIT];

    timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we[g]),
      .en_d_i    (wdata_i[EN_BIT]),
      .term_d_i  (wdata_i[CNT_W-1:0]),
      .clr_i     (clr[g]),
      .en_o      (en[g]),
      .term_o    (term[g]),
      .cnt_o     (cnt[g]),
      .hit_o     (hit[g])
    );
  end

  timer_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_we_i  (mask_we),
    .mask_d_i   (wdata_i[NUM_CH-1:0]),
    .stat_clr_i (stat_clr),
    .hit_i      (hit),
    .mask_o     (mask),
    .stat_o     (stat),
    .ch_irq_o   (ch_irq_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(CTRL_BASE + i)) rdata_o = {en[i], 1'b0, term[i]};
      if (addr_i == ADDR_W'(CNT_BASE + i))  rdata_o = {2'b00, cnt[i]};
    end
    if (addr_i == ADDR_W'(MASK_ADDR)) rdata_o = {{(DATA_W-NUM_CH){1'b0}}, mask};
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = {{(DATA_W-NUM_CH){1'b0}}, stat};
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 62
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_CH-1:0]            en,
  input logic [NUM_CH-1:0]            clr,
  input logic [NUM_CH-1:0]            hit,
  input logic [NUM_CH-1:0]            stat,
  input logic [NUM_CH-1:0]            mask,
  input logic [NUM_CH-1:0]            stat_clr,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic                         irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en[g] && !clr[g]) |=> $stable(cnt[g]));
    p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en[g] && !clr[g] && !hit[g]) |=> (cnt[g] == $past(cnt[g]) + 1'b1));
    p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[g] |=> (cnt[g] == '0));
    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[g] |=> (cnt[g] == '0));
    p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat[g] && !stat_clr[g]) |=> stat[g]);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[g] && stat_clr[g]) |=> stat[g]);
  end

  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat != '0) && (mask != '0)));
endmodule

bind timer_bank timer_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (en),
  .clr      (clr),
  .hit      (hit),
  .stat     (stat),
  .mask     (mask),
  .stat_clr (stat_clr),
  .cnt      (cnt),
  .irq_o    (irq_o)
);

// File: tb/timer_bank_tb_top.sv
module timer_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'd0, A_CNT = 4'd4, A_MASK = 4'd8, A_STAT = 4'd9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic [3:0]  ch_irq_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  timer_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ch_irq_o(ch_irq_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] ctl(bit en, bit clr, logic [61:0] term);
    return {en, clr, term};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [63:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1 reg zero", d, 64'd0);
    end
    check("R1 irq low", {59'd0, ch_irq_o, irq_o}, 64'd0);
  endtask

  task automatic t_count_hold;
    logic [63:0] d;
    wr(A_CTRL + 0, ctl(1, 0, 62'd9));
    edges(5);
    rd(A_CNT + 0, d);
    check("R4 count up", d, 64'd5);
    rd(A_CTRL + 0, d);
    check("R2 ctrl readback", d, ctl(1, 0, 62'd9));
    wr(A_CTRL + 0, ctl(0, 0, 62'd9));
    edges(3);
    rd(A_CNT + 0, d);
    check("R4 disabled hold", d, 64'd6);
  endtask

  task automatic t_wrap;
    logic [63:0] d;
    wr(A_CTRL + 1, ctl(1, 1, 62'd3));
    rd(A_CTRL + 1, d);
    check("R6 clear bit reads 0", d, ctl(1, 0, 62'd3));
    edges(3);
    rd(A_CNT + 1, d);
    check("R5 at terminal", d, 64'd3);
    rd(A_STAT, d);
    check("R5 no pending yet", d, 64'd0);
    edges(1);
    rd(A_CNT + 1, d);
    check("R5 wrapped to zero", d, 64'd0);
    rd(A_STAT, d);
    check("R5 pending set", d, 64'd2);
    wr(A_CTRL + 1, ctl(0, 0, 62'd3));
  endtask

  task automatic t_w1c;
    logic [63:0] d;
    wr(A_STAT, 64'd0);
    rd(A_STAT, d);
    check("R8 write 0 no effect", d, 64'd2);
    wr(A_STAT, 64'd2);
    rd(A_STAT, d);
    check("R8 write 1 clears", d, 64'd0);
  endtask

  task automatic t_set_wins;
    logic [63:0] d;
    wr(A_CTRL + 1, ctl(1, 1, 62'd3));
    edges(3);
    wr(A_STAT, 64'd2);
    rd(A_STAT, d);
    check("R9 set beats clear", d, 64'd2);
    rd(A_CNT + 1, d);
    check("R9 count wrapped", d, 64'd0);
    wr(A_STAT, 64'd2);
    rd(A_STAT, d);
    check("R8 later clear", d, 64'd0);
    wr(A_CTRL + 1, ctl(0, 0, 62'd3));
  endtask

  task automatic t_clear_disabled;
    logic [63:0] d;
    wr(A_CTRL + 0, ctl(0, 1, 62'd9));
    rd(A_CNT + 0, d);
    check("R6 clear while disabled", d, 64'd0);
  endtask

  task automatic t_irq;
    logic [63:0] d;
    wr(A_CTRL + 1, ctl(1, 1, 62'd3));
    edges(4);
    wr(A_CTRL + 1, ctl(0, 0, 62'd3));
    check("R10 masked off", {59'd0, ch_irq_o, irq_o}, 64'd0);
    wr(A_MASK, 64'd2);
    check("R10 ch line", {60'd0, ch_irq_o}, 64'd2);
    check("R10 combined", {63'd0, irq_o}, 64'd1);
    rd(A_MASK, d);
    check("R7 mask readback", d, 64'd2);
    wr(A_MASK, '1);
    rd(A_MASK, d);
    check("R7 upper mask bits zero", d, 64'hF);
    wr(A_STAT, '1);
    rd(A_STAT, d);
    check("R7 status cleared", d, 64'd0);
    check("R10 combined low", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_count_ro;
    logic [63:0] d;
    wr(A_CNT + 1, 64'h123);
    rd(A_CNT + 1, d);
    check("R3 count write ignored", d, 64'd1);
  endtask

  task automatic t_indep;
    logic [63:0] d;
    wr(A_CTRL + 2, ctl(1, 1, 62'h3FFF_FFFF_FFFF_FFFF));
    rd(A_CTRL + 2, d);
    check("R2 full terminal", d, ctl(1, 0, 62'h3FFF_FFFF_FFFF_FFFF));
    edges(10);
    rd(A_CNT + 2, d);
    check("R11 ch2 runs", d, 64'd10);
    rd(A_CNT + 3, d);
    check("R11 ch3 idle", d, 64'd0);
    rd(A_CNT + 1, d);
    check("R11 ch1 untouched", d, 64'd1);
    rd(A_CNT + 2, d);
    check("R3 upper bits zero", {62'd0, d[63:62]}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    edges(2);
    t_reset();
    rst_ni = 1'b1;
    edges(1);
    t_count_hold();
    t_wrap();
    t_w1c();
    t_set_wins();
    t_clear_disabled();
    t_irq();
    t_count_ro();
    t_indep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule